// File: doc/BRIEF.md
# UART Receive/Transmit FIFO Controller with Trigger and Character Timeout

This block holds the byte queues that sit between a UART's host-side register port and its serial bit engines. A host writes one control byte that turns queueing on or off, empties either queue on demand and selects how full the receive queue must be before it raises its threshold flag. The host also pushes bytes to send and pops bytes that have arrived. The line side pushes bytes as the receiver assembles them and pops bytes when the transmitter is ready for the next one.

A character-time pulse comes from the baud logic, one pulse per frame time. It drives an idle timer on the receive queue. When received data has gone untouched for four character times, a pending flag is raised so that the host can collect a short tail of bytes that never reached the threshold. When queueing is disabled, each side holds a single byte, as a plain holding register would.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: A control write keeps only bits 0 (enable), 3 (DMA select) and 7:6 (trigger code) in `cfg_q`. Bits 1 (receive clear), 2 (transmit clear) and 5:4 always read back as zero.
- R2: While enabled, trigger code 2'b00, 2'b01, 2'b10 and 2'b11 gives `trig_level` 1, 4, 8 and 14. `rx_trig_hit` is high exactly when `rx_count` >= `trig_level`.
- R3: While enabled, each queue holds up to 16 bytes and returns them in arrival order. A push and a pop in the same cycle both take effect.
- R4: A push into a full queue is dropped and the count does not change. On the receive side, the drop sets `overrun`, which stays set until the receive queue is cleared.
- R5: A control write with bit 1 set empties the receive queue and clears `overrun` and `break_flag`. A write with bit 2 set empties the transmit queue. Each clear leaves the other queue untouched.
- R6: A control write whose bit 0 differs from the stored enable bit empties both queues, whatever bits 1 and 2 hold.
- R7: While enabled, `timeout_pend` rises after the fourth `char_tick` that follows the latest line push, or the latest host pop that leaves data behind, provided the receive queue still holds data. A push or such a pop restarts the count.
- R8: A host pop clears `timeout_pend` and a pop that empties the queue stops the timer. A receive clear drops `timeout_pend` and stops the timer.
- R9: `host_rx_data` and `line_tx_data` show the oldest byte of their queue and read as zero when it is empty. A pop from an empty queue changes nothing.
- R10: `data_ready` is high when the receive queue is non-empty or `break_flag` is set. `line_rx_break` sets `break_flag`, and a host pop that empties the queue clears it.
- R11: `thr_empty` is high when the transmit queue is empty. `tx_empty` is high only when the queue is also empty and `line_tx_busy` is low.
- R12: While disabled, each queue holds a single byte, `trig_level` is 1 and `timeout_pend` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte |
| host_tx_push | input | 1 | Host pushes a byte to send |
| host_tx_data | input | 8 | Byte to send |
| host_rx_pop | input | 1 | Host pops the oldest received byte |
| host_rx_data | output | 8 | Oldest received byte, zero when empty |
| line_rx_push | input | 1 | Receiver delivers a byte |
| line_rx_data | input | 8 | Received byte |
| line_rx_break | input | 1 | Receiver saw a break condition |
| line_tx_pop | input | 1 | Transmitter takes the oldest byte |
| line_tx_data | output | 8 | Oldest byte to send, zero when empty |
| line_tx_busy | input | 1 | Transmit shift register still sending |
| char_tick | input | 1 | One pulse per character time |
| cfg_q | output | 8 | Retained control bits |
| fifo_en | output | 1 | Queueing enabled |
| trig_level | output | 5 | Decoded receive threshold in bytes |
| rx_count | output | 5 | Bytes in the receive queue |
| tx_count | output | 5 | Bytes in the transmit queue |
| rx_trig_hit | output | 1 | Receive count at or above the threshold |
| data_ready | output | 1 | Received data or break available |
| break_flag | output | 1 | Break seen and not yet consumed |
| overrun | output | 1 | A received byte was dropped |
| thr_empty | output | 1 | Transmit queue empty |
| tx_empty | output | 1 | Transmit queue and shift register idle |
| timeout_pend | output | 1 | Receive character timeout pending |

## Verification
The assertions check, on every cycle, the invariants that need no history. Counts never pass the depth, and a dropped push or an empty pop leaves the count alone. An enable toggle leaves both queues empty. The pending flag only rises after a character tick and falls after a receive clear. A disabled queue never holds more than one byte, and `tx_empty` implies `thr_empty`. Only the bench scenarios show the byte order through wrap-around, the exact tick on which the timeout fires and how the timer restarts on pops. They also show the trigger thresholds at each code and how overrun and break are set and released by host activity.

// File: rtl/uart_fq_pkg.sv
package uart_fq_pkg;

    localparam int FQ_DEPTH      = 16;
    localparam int FQ_DATA_W     = 8;
    localparam int FQ_TO_CHARS   = 4;
    localparam logic [7:0] FQ_CFG_KEEP = 8'hC9;

    typedef enum logic [1:0] {
        TRIG_ONE      = 2'b00,
        TRIG_FOUR     = 2'b01,
        TRIG_EIGHT    = 2'b10,
        TRIG_FOURTEEN = 2'b11
    } trig_code_e;

    typedef struct packed {
        trig_code_e trig;
        logic [1:0] spare;
        logic       dma_sel;
        logic       tx_clear;
        logic       rx_clear;
        logic       enable;
    } fq_cfg_t;

    function automatic int unsigned trig_bytes(trig_code_e code);
        case (code)
            TRIG_ONE:      return 1;
            TRIG_FOUR:     return 4;
            TRIG_EIGHT:    return 8;
            default:       return 14;
        endcase
    endfunction

endpackage

// File: rtl/fq_cfg_reg.sv
module fq_cfg_reg
    import uart_fq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [7:0]       wdata,
    output logic [7:0]       cfg_q,
    output logic             en,
    output logic [CNT_W-1:0] trig_level,
    output logic             rx_flush,
    output logic             tx_flush
);
    fq_cfg_t stored;
    fq_cfg_t incoming;
    logic    en_toggle;

    assign incoming  = fq_cfg_t'(wdata);
    assign en_toggle = wr && (incoming.enable != stored.enable);
    assign rx_flush  = (wr && incoming.rx_clear) || en_toggle;
    assign tx_flush  = (wr && incoming.tx_clear) || en_toggle;

    always_ff @(posedge clk) begin
        if (rst) begin
            stored <= '0;
        end else if (wr) begin
            stored <= fq_cfg_t'(wdata & FQ_CFG_KEEP);
        end
    end

    assign cfg_q      = stored;
    assign en         = stored.enable;
    assign trig_level = stored.enable ? CNT_W'(trig_bytes(stored.trig)) : CNT_W'(1);

    a_r1_clear_bits_low: assert property (@(posedge clk) disable iff (rst)
        wr |=> (cfg_q[2:1] == 2'b00) && (cfg_q[5:4] == 2'b00));

endmodule

// File: rtl/fq_byte_ring.sv
module fq_byte_ring #(
    parameter int DEPTH  = 16,
    parameter int DW     = 8,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             single,
    input  logic             push,
    input  logic [DW-1:0]    wdata,
    input  logic             pop,
    output logic [DW-1:0]    rdata,
    output logic [CNT_W-1:0] count,
    output logic             pop_ok,
    output logic             push_drop
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0]    store [DEPTH];
    logic [PTR_W-1:0] head;
    logic [PTR_W-1:0] tail;
    logic             full;
    logic             empty;
    logic             push_ok;

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign empty     = (count == '0);
    assign full      = single ? !empty : (count == CNT_W'(DEPTH));
    assign pop_ok    = pop && !empty;
    assign push_ok   = push && (!full || pop_ok);
    assign push_drop = push && !push_ok;
    assign rdata     = empty ? '0 : store[tail];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (push_ok) head <= bump(head);
            if (pop_ok)  tail <= bump(tail);
            count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok && !flush) store[head] <= wdata;
    end

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    a_r4_drop_keeps_count: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop && !flush) |=> $stable(count));

    a_r9_empty_pop_idle: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push && !flush) |=> (count == '0));

endmodule

// File: rtl/fq_rx_timeout.sv
module fq_rx_timeout #(
    parameter int TO_CHARS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic cancel,
    input  logic restart,
    input  logic ack,
    input  logic tick,
    input  logic has_data,
    output logic pending
);
    localparam int TW = $clog2(TO_CHARS + 1);

    logic [TW-1:0] ticks;
    logic          armed;

    always_ff @(posedge clk) begin
        if (rst || cancel || !enable) begin
            ticks   <= '0;
            armed   <= 1'b0;
            pending <= 1'b0;
        end else begin
            if (ack) pending <= 1'b0;
            if (restart) begin
                ticks <= '0;
                armed <= 1'b1;
            end else if (ack) begin
                armed <= 1'b0;
            end else if (armed && tick) begin
                if (ticks == TW'(TO_CHARS - 1)) begin
                    armed <= 1'b0;
                    if (has_data) pending <= 1'b1;
                end else begin
                    ticks <= ticks + TW'(1);
                end
            end
        end
    end

    a_r7_rise_after_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(pending) |-> $past(tick));

    a_r8_cancel_drops: assert property (@(posedge clk) disable iff (rst)
        cancel |=> !pending);

endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
    import uart_fq_pkg::*;
#(
    parameter int DEPTH    = FQ_DEPTH,
    parameter int DW       = FQ_DATA_W,
    parameter int TO_CHARS = FQ_TO_CHARS,
    parameter int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [7:0]       cfg_wdata,
    input  logic             host_tx_push,
    input  logic [DW-1:0]    host_tx_data,
    input  logic             host_rx_pop,
    output logic [DW-1:0]    host_rx_data,
    input  logic             line_rx_push,
    input  logic [DW-1:0]    line_rx_data,
    input  logic             line_rx_break,
    input  logic             line_tx_pop,
    output logic [DW-1:0]    line_tx_data,
    input  logic             line_tx_busy,
    input  logic             char_tick,
    output logic [7:0]       cfg_q,
    output logic             fifo_en,
    output logic [CNT_W-1:0] trig_level,
    output logic [CNT_W-1:0] rx_count,
    output logic [CNT_W-1:0] tx_count,
    output logic             rx_trig_hit,
    output logic             data_ready,
    output logic             break_flag,
    output logic             overrun,
    output logic             thr_empty,
    output logic             tx_empty,
    output logic             timeout_pend
);
    logic rx_flush, tx_flush;
    logic rx_pop_ok, rx_drop;
    logic tx_pop_ok, tx_drop;
    logic to_restart;

    fq_cfg_reg #(.CNT_W(CNT_W)) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .wr         (cfg_wr),
        .wdata      (cfg_wdata),
        .cfg_q      (cfg_q),
        .en         (fifo_en),
        .trig_level (trig_level),
        .rx_flush   (rx_flush),
        .tx_flush   (tx_flush)
    );

    fq_byte_ring #(.DEPTH(DEPTH), .DW(DW), .CNT_W(CNT_W)) u_rx_ring (
        .clk       (clk),
        .rst       (rst),
        .flush     (rx_flush),
        .single    (!fifo_en),
        .push      (line_rx_push),
        .wdata     (line_rx_data),
        .pop       (host_rx_pop),
        .rdata     (host_rx_data),
        .count     (rx_count),
        .pop_ok    (rx_pop_ok),
        .push_drop (rx_drop)
    );

    fq_byte_ring #(.DEPTH(DEPTH), .DW(DW), .CNT_W(CNT_W)) u_tx_ring (
        .clk       (clk),
        .rst       (rst),
        .flush     (tx_flush),
        .single    (!fifo_en),
        .push      (host_tx_push),
        .wdata     (host_tx_data),
        .pop       (line_tx_pop),
        .rdata     (line_tx_data),
        .count     (tx_count),
        .pop_ok    (tx_pop_ok),
        .push_drop (tx_drop)
    );

    assign to_restart = line_rx_push || (rx_pop_ok && (rx_count > CNT_W'(1)));

    fq_rx_timeout #(.TO_CHARS(TO_CHARS)) u_timeout (
        .clk      (clk),
        .rst      (rst),
        .enable   (fifo_en),
        .cancel   (rx_flush),
        .restart  (to_restart),
        .ack      (rx_pop_ok),
        .tick     (char_tick),
        .has_data (rx_count != '0),
        .pending  (timeout_pend)
    );

    always_ff @(posedge clk) begin
        if (rst || rx_flush) begin
            overrun    <= 1'b0;
            break_flag <= 1'b0;
        end else begin
            if (rx_drop) overrun <= 1'b1;
            if (line_rx_break)
                break_flag <= 1'b1;
            else if (rx_pop_ok && (rx_count == CNT_W'(1)) && !line_rx_push)
                break_flag <= 1'b0;
        end
    end

    assign data_ready  = (rx_count != '0) || break_flag;
    assign rx_trig_hit = (rx_count >= trig_level);
    assign thr_empty   = (tx_count == '0);
    assign tx_empty    = thr_empty && !line_tx_busy;

    a_r6_toggle_empties: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && (cfg_wdata[0] != fifo_en)) |=> (rx_count == '0) && (tx_count == '0));

    a_r11_temt_needs_thre: assert property (@(posedge clk) disable iff (rst)
        tx_empty |-> thr_empty);

    a_r12_single_slot: assert property (@(posedge clk) disable iff (rst)
        !fifo_en |-> (rx_count <= CNT_W'(1)) && (tx_count <= CNT_W'(1)));

    a_r12_no_timeout_off: assert property (@(posedge clk) disable iff (rst)
        (!fifo_en && !$past(fifo_en)) |-> !timeout_pend);

    a_r4_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        (overrun && !cfg_wr) |=> overrun);

endmodule

// File: tb/uart_fifo_ctrl_tb_top.sv
`timescale 1ns/1ps
module uart_fifo_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_wr = 0;
    logic [7:0] cfg_wdata = 0;
    logic       host_tx_push = 0;
    logic [7:0] host_tx_data = 0;
    logic       host_rx_pop = 0;
    logic [7:0] host_rx_data;
    logic       line_rx_push = 0;
    logic [7:0] line_rx_data = 0;
    logic       line_rx_break = 0;
    logic       line_tx_pop = 0;
    logic [7:0] line_tx_data;
    logic       line_tx_busy = 0;
    logic       char_tick = 0;
    logic [7:0] cfg_q;
    logic       fifo_en;
    logic [4:0] trig_level, rx_count, tx_count;
    logic       rx_trig_hit, data_ready, break_flag, overrun;
    logic       thr_empty, tx_empty, timeout_pend;

    always #2.5 clk = ~clk;

    uart_fifo_ctrl dut_i (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .host_tx_push(host_tx_push), .host_tx_data(host_tx_data),
        .host_rx_pop(host_rx_pop), .host_rx_data(host_rx_data),
        .line_rx_push(line_rx_push), .line_rx_data(line_rx_data),
        .line_rx_break(line_rx_break), .line_tx_pop(line_tx_pop),
        .line_tx_data(line_tx_data), .line_tx_busy(line_tx_busy),
        .char_tick(char_tick), .cfg_q(cfg_q), .fifo_en(fifo_en),
        .trig_level(trig_level), .rx_count(rx_count), .tx_count(tx_count),
        .rx_trig_hit(rx_trig_hit), .data_ready(data_ready),
        .break_flag(break_flag), .overrun(overrun), .thr_empty(thr_empty),
        .tx_empty(tx_empty), .timeout_pend(timeout_pend)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference state
    logic [7:0] m_rx[$];
    logic [7:0] m_tx[$];
    logic [7:0] m_cfg = 0;
    bit m_ovr = 0, m_brk = 0, m_pend = 0, m_armed = 0;
    int m_ticks = 0;

    function automatic int exp_trig(logic [7:0] c);
        if (!c[0]) return 1;
        case (c[7:6])
            2'b00: return 1;
            2'b01: return 4;
            2'b10: return 8;
            default: return 14;
        endcase
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_update();
        bit en = m_cfg[0];
        int cap = en ? 16 : 1;
        bit tog = cfg_wr && (cfg_wdata[0] != m_cfg[0]);
        bit rxf = (cfg_wr && cfg_wdata[1]) || tog;
        bit txf = (cfg_wr && cfg_wdata[2]) || tog;
        int rpre = m_rx.size();
        int tpre = m_tx.size();
        bit rpop = host_rx_pop && rpre > 0;
        bit tpop = line_tx_pop && tpre > 0;
        bit rpush = line_rx_push && (rpre < cap || rpop);
        bit tpush = host_tx_push && (tpre < cap || tpop);
        if (rxf) begin
            m_rx.delete(); m_ovr = 0; m_brk = 0; m_pend = 0; m_armed = 0; m_ticks = 0;
        end else begin
            if (rpop) void'(m_rx.pop_front());
            if (rpush) m_rx.push_back(line_rx_data);
            else if (line_rx_push) m_ovr = 1;
            if (line_rx_break) m_brk = 1;
            else if (rpop && rpre == 1 && !line_rx_push) m_brk = 0;
            if (!en) begin
                m_pend = 0; m_armed = 0; m_ticks = 0;
            end else begin
                if (rpop) m_pend = 0;
                if (line_rx_push || (rpop && rpre > 1)) begin
                    m_ticks = 0; m_armed = 1;
                end else if (rpop) begin
                    m_armed = 0;
                end else if (m_armed && char_tick) begin
                    if (m_ticks == 3) begin
                        m_armed = 0;
                        if (rpre > 0) m_pend = 1;
                    end else m_ticks++;
                end
            end
        end
        if (txf) m_tx.delete();
        else begin
            if (tpop) void'(m_tx.pop_front());
            if (tpush) m_tx.push_back(host_tx_data);
        end
        if (cfg_wr) m_cfg = cfg_wdata & 8'hC9;
    endtask

    task automatic compare_all();
        chk("R1", "cfg_q", cfg_q, m_cfg);
        chk("R2", "trig_level", trig_level, exp_trig(m_cfg));
        chk("R2", "rx_trig_hit", rx_trig_hit, m_rx.size() >= exp_trig(m_cfg));
        chk("R3", "rx_count", rx_count, m_rx.size());
        chk("R3", "tx_count", tx_count, m_tx.size());
        chk("R9", "host_rx_data", host_rx_data, m_rx.size() ? m_rx[0] : 0);
        chk("R9", "line_tx_data", line_tx_data, m_tx.size() ? m_tx[0] : 0);
        chk("R4", "overrun", overrun, m_ovr);
        chk("R10", "break_flag", break_flag, m_brk);
        chk("R10", "data_ready", data_ready, (m_rx.size() > 0) || m_brk);
        chk("R7", "timeout_pend", timeout_pend, m_pend);
        chk("R11", "thr_empty", thr_empty, m_tx.size() == 0);
        chk("R11", "tx_empty", tx_empty, (m_tx.size() == 0) && !line_tx_busy);
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        model_update();
        compare_all();
        cfg_wr = 0; host_tx_push = 0; host_rx_pop = 0;
        line_rx_push = 0; line_rx_break = 0; line_tx_pop = 0; char_tick = 0;
    endtask

    task automatic wcfg(logic [7:0] v);
        cfg_wr = 1; cfg_wdata = v; step();
    endtask

    task automatic rx_in(logic [7:0] v);
        line_rx_push = 1; line_rx_data = v; step();
    endtask

    task automatic tick();
        char_tick = 1; step();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // reset state (R1, R11)
        chk("R1", "reset cfg_q", cfg_q, 0);
        chk("R11", "reset thr_empty", thr_empty, 1);
        chk("R11", "reset tx_empty", tx_empty, 1);
        chk("R10", "reset data_ready", data_ready, 0);

        // R1/R2: enable, clear both, trigger 14
        wcfg(8'hFF);
        chk("R1", "masked cfg", cfg_q, 8'hC9);
        chk("R2", "trig 14", trig_level, 14);

        // R3/R4: fill 16 then overflow
        for (int i = 0; i < 17; i++) rx_in(8'(8'h30 + i));
        chk("R3", "full count", rx_count, 16);
        chk("R4", "overrun set", overrun, 1);
        chk("R2", "hit at 16", rx_trig_hit, 1);
        for (int i = 0; i < 16; i++) begin
            chk("R3", "order", host_rx_data, 8'h30 + i);
            host_rx_pop = 1; step();
        end
        chk("R9", "empty read zero", host_rx_data, 0);
        host_rx_pop = 1; step();
        chk("R9", "empty pop count", rx_count, 0);

        // R2: each trigger code
        wcfg(8'h43);
        for (int i = 0; i < 4; i++) rx_in(8'(i));
        chk("R2", "trig 4 hit", rx_trig_hit, 1);
        wcfg(8'h83);
        chk("R2", "trig 8 level", trig_level, 8);
        wcfg(8'h03);
        chk("R2", "trig 1 level", trig_level, 1);

        // R7/R8: timeout after four ticks
        rx_in(8'hA5);
        repeat (3) tick();
        chk("R7", "no pend after 3", timeout_pend, 0);
        tick();
        chk("R7", "pend after 4", timeout_pend, 1);
        host_rx_pop = 1; step();
        chk("R8", "pop clears pend", timeout_pend, 0);
        rx_in(8'h11); rx_in(8'h12);
        repeat (4) tick();
        chk("R7", "pend again", timeout_pend, 1);
        wcfg(8'h03);
        chk("R8", "rx clear drops pend", timeout_pend, 0);
        chk("R5", "rx clear count", rx_count, 0);
        repeat (5) tick();
        chk("R8", "timer stopped", timeout_pend, 0);

        // R10: break
        line_rx_break = 1; step();
        chk("R10", "break dr", data_ready, 1);
        rx_in(8'h55);
        host_rx_pop = 1; step();
        chk("R10", "break cleared", break_flag, 0);

        // R11: transmit side
        for (int i = 0; i < 3; i++) begin host_tx_push = 1; host_tx_data = 8'(8'hB0 + i); step(); end
        chk("R11", "thr not empty", thr_empty, 0);
        line_tx_busy = 1;
        for (int i = 0; i < 3; i++) begin
            chk("R3", "tx order", line_tx_data, 8'hB0 + i);
            line_tx_pop = 1; step();
        end
        chk("R11", "thre set", thr_empty, 1);
        chk("R11", "temt waits", tx_empty, 0);
        line_tx_busy = 0; step();
        chk("R11", "temt set", tx_empty, 1);

        // R5: tx clear leaves rx
        rx_in(8'h77); host_tx_push = 1; host_tx_data = 8'h99; step();
        wcfg(8'h05);
        chk("R5", "tx cleared", tx_count, 0);
        chk("R5", "rx kept", rx_count, 1);

        // R6: toggle enable off empties both
        host_tx_push = 1; step();
        wcfg(8'hC0);
        chk("R6", "rx empty on toggle", rx_count, 0);
        chk("R6", "tx empty on toggle", tx_count, 0);
        // R12: disabled single slot
        rx_in(8'h01); rx_in(8'h02);
        chk("R12", "single rx", rx_count, 1);
        chk("R12", "trig 1 off", trig_level, 1);
        chk("R4", "overrun off mode", overrun, 1);
        repeat (5) tick();
        chk("R12", "no pend off", timeout_pend, 0);
        wcfg(8'h01);
        chk("R6", "toggle on empties", rx_count, 0);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            line_rx_push  = ($urandom % 100) < 40;
            line_rx_data  = 8'($urandom);
            host_rx_pop   = ($urandom % 100) < 35;
            host_tx_push  = ($urandom % 100) < 30;
            host_tx_data  = 8'($urandom);
            line_tx_pop   = ($urandom % 100) < 30;
            char_tick     = ($urandom % 100) < 30;
            line_rx_break = ($urandom % 100) < 2;
            if (($urandom % 100) < 10) line_tx_busy = ~line_tx_busy;
            if (($urandom % 100) < 2) begin
                cfg_wr = 1;
                cfg_wdata = 8'($urandom) & 8'hCE;
                cfg_wdata[0] = (($urandom % 10) != 0);
            end
            step();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule